// File: doc/BRIEF.md
# DRAM Row/Column Address Sequencer

This block converts a single word access, as issued by a processor's address generator, into a DRAM access sequence. It is intended for data-delay buffers held in DRAM. Once a request is accepted, the block presents the row part of the word address on a multiplexed address bus with the RAS strobe asserted, for a slow out-of-page interval. It then presents one or more column addresses with both RAS and CAS asserted, each for a shorter in-page interval. Each column address is built from the low part of the word address with 0 to 3 counter bits appended below it. After the last column phase, RAS drops, a one-cycle done pulse is raised, and the block becomes ready again.

The sequencer responds only to requests whose 4-bit addressing-mode field has the form 01xx. Other mode values leave it idle. The word address and all configuration inputs are captured in the cycle a request is accepted and are held for the whole sequence. The configuration inputs are the number of row bits, the number of extension bits, the slow wait and the fast wait.

The control is a four-state machine:

- `ST_IDLE`: ready, bus parked at zero.
- `ST_ROW`: RAS phase.
- `ST_COL`: RAS and CAS phases, one per extension count.
- `ST_DONE`: strobes off, done pulse.

The transitions are:

- `ST_IDLE`→`ST_ROW` on an accepted request.
- `ST_ROW`→`ST_COL` when the slow timer expires.
- `ST_COL`→`ST_COL` when the fast timer expires and more counts remain; this step advances the extension counter.
- `ST_COL`→`ST_DONE` when the fast timer expires on the last count.
- `ST_DONE`→`ST_IDLE` unconditionally.

Top module: `dram_rc_seq`

## Requirements
- R1: After reset, ready is 1, ras, cas and done are 0, and mem_addr is all zeros.
- R2: A request whose mode has bits [3:2] other than 2'b01 is ignored: ready stays 1, the strobes stay 0 and mem_addr stays 0 in the following cycles.
- R3: A request seen with ready high and mode[3:2]=2'b01 is accepted. For the next S cycles, ras=1, cas=0, and mem_addr equals the word address shifted right by (16 − row_bits), zero-filled above. S is the captured slow wait.
- R4: In each column phase, mem_addr equals the low (16 − row_bits) word-address bits shifted left by ext_bits, OR'ed with the extension count, with every higher pin at 0.
- R5: There are exactly 2^ext_bits column phases. The extension count starts at 0 and rises by 1 per phase.
- R6: Each column phase lasts F cycles with ras=1 and cas=1, where F is the captured fast wait. cas is never 1 while ras is 0.
- R7: The cycle after the last column phase has ras=0, cas=0, done=1, ready=0 and mem_addr=0. In the following cycle, ready is 1 and done is 0.
- R8: ready is 0 from the cycle after acceptance until the cycle after done. Requests made while ready is 0 are ignored.
- R9: Changes to the word address, configuration or mode after acceptance do not alter the running sequence.
- R10: While ready is 1, mem_addr is all zeros and both strobes are 0.
- R11: Configuration is clamped at capture:
  - A slow wait below 2 acts as 2.
  - A fast wait of 0 acts as 1.
  - A row-bit count of 0 acts as 1.
  - A row-bit count above 15 acts as 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, taken when ready is 1 |
| mode | input | 4 | Addressing mode; active when bits [3:2] are 01 |
| word_addr | input | 16 | Word address to translate |
| cfg_row_bits | input | 5 | Number of upper address bits forming the row |
| cfg_ext_bits | input | 2 | Number of extension bits appended to the column |
| cfg_slow_wait | input | 4 | Cycles of the row phase (2 to 15) |
| cfg_fast_wait | input | 3 | Cycles of each column phase (1 to 7) |
| ready | output | 1 | Idle and able to accept a request |
| mem_addr | output | 18 | Multiplexed row/column address bus |
| ras | output | 1 | Row strobe, active high |
| cas | output | 1 | Column strobe, active high |
| done | output | 1 | One-cycle pulse closing a sequence |

## Verification
Every output is decoded from registered state, so the first row cycle is visible in the cycle after the accepting edge. The trace then follows a fixed cycle order:

- the row cycles (R3);
- F cycles per extension count (R4–R6);
- one done cycle (R7);
- a ready cycle.

From the clamped configuration, the driver computes this entire cycle-by-cycle trace and queues one expected item per cycle, starting right after the accepting edge. The monitor pops one item at each falling clock edge, away from the active edge, and compares all outputs, so every result is checked in exactly the cycle it is due. Ignored requests (R2, R8, R9) are covered by queuing idle or unchanged items for the cycles after the disturbing stimulus.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROW  = 2'd1,
        ST_COL  = 2'd2,
        ST_DONE = 2'd3
    } seq_state_t;

    // Upper two bits of the addressing mode that enable this sequencer
    localparam logic [1:0] MODE_ACTIVE = 2'b01;

    localparam int SLOW_MIN = 2;
    localparam int FAST_MIN = 1;

endpackage

// File: rtl/dram_wait_timer.sv
module dram_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Loaded with the phase length minus one, counts down to zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - CNT_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/dram_ext_counter.sv
module dram_ext_counter #(
    parameter int EXT_W = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [EXT_W-1:0] ext_bits,
    output logic [CNT_W-1:0] count,
    output logic             at_last
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Final count is 2^ext_bits - 1
    always_comb begin
        limit = CNT_W'((32'd1 << ext_bits) - 32'd1);
    end

    assign count   = cnt_q;
    assign at_last = (cnt_q == limit);

endmodule

// File: rtl/dram_addr_former.sv
module dram_addr_former #(
    parameter int ADDR_W = 16,
    parameter int RB_W   = 5,
    parameter int EXT_W  = 2,
    parameter int CNT_W  = 3,
    parameter int MA_W   = 19
) (
    input  logic [ADDR_W-1:0] word,
    input  logic [RB_W-1:0]   row_bits,
    input  logic [EXT_W-1:0]  ext_bits,
    input  logic [CNT_W-1:0]  ext_cnt,
    input  logic              sel_row,
    input  logic              sel_col,
    output logic [MA_W-1:0]   ma
);

    localparam int PAD_W = MA_W - ADDR_W;

    logic [RB_W-1:0]   col_bits;
    logic [ADDR_W-1:0] col_mask;
    logic [MA_W-1:0]   row_val;
    logic [MA_W-1:0]   col_low;
    logic [MA_W-1:0]   col_val;

    assign col_bits = RB_W'(ADDR_W) - row_bits;

    // One mask bit per address bit: kept when it belongs to the column part
    for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_mask
        assign col_mask[gi] = (RB_W'(gi) < col_bits);
    end

    always_comb begin
        row_val = {{PAD_W{1'b0}}, word} >> col_bits;
        col_low = {{PAD_W{1'b0}}, word & col_mask};
        col_val = (col_low << ext_bits) | MA_W'(ext_cnt);
        if (sel_row) begin
            ma = row_val;
        end else if (sel_col) begin
            ma = col_val;
        end else begin
            ma = '0;
        end
    end

endmodule

// File: rtl/dram_rc_seq.sv
module dram_rc_seq
    import dram_seq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int EXT_W  = 2,
    parameter int SLOW_W = 4,
    parameter int FAST_W = 3,
    parameter int RB_W   = $clog2(ADDR_W + 1),
    parameter int MA_W   = ADDR_W + (2 ** EXT_W) - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [3:0]        mode,
    input  logic [ADDR_W-1:0] word_addr,
    input  logic [RB_W-1:0]   cfg_row_bits,
    input  logic [EXT_W-1:0]  cfg_ext_bits,
    input  logic [SLOW_W-1:0] cfg_slow_wait,
    input  logic [FAST_W-1:0] cfg_fast_wait,
    output logic              ready,
    output logic [MA_W-1:0]   mem_addr,
    output logic              ras,
    output logic              cas,
    output logic              done
);

    localparam int CNT_W   = (2 ** EXT_W) - 1;
    localparam int TMR_W   = (SLOW_W > FAST_W) ? SLOW_W : FAST_W;
    localparam int ROW_MAX = ADDR_W - 1;

    seq_state_t state_q, state_d;

    logic [ADDR_W-1:0] word_q;
    logic [RB_W-1:0]   rb_q;
    logic [EXT_W-1:0]  eb_q;
    logic [FAST_W-1:0] fast_q;

    logic [RB_W-1:0]   rb_clamp;
    logic [SLOW_W-1:0] slow_clamp;
    logic [FAST_W-1:0] fast_clamp;

    logic              accept;
    logic              tmr_last;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              ext_last;
    logic              ext_step;
    logic [CNT_W-1:0]  ext_cnt;

    assign accept = (state_q == ST_IDLE) && req && (mode[3:2] == MODE_ACTIVE);

    // Configuration clamping
    always_comb begin
        rb_clamp = cfg_row_bits;
        if (cfg_row_bits == '0) begin
            rb_clamp = RB_W'(1);
        end else if (cfg_row_bits > RB_W'(ROW_MAX)) begin
            rb_clamp = RB_W'(ROW_MAX);
        end
        slow_clamp = (cfg_slow_wait < SLOW_W'(SLOW_MIN)) ? SLOW_W'(SLOW_MIN) : cfg_slow_wait;
        fast_clamp = (cfg_fast_wait < FAST_W'(FAST_MIN)) ? FAST_W'(FAST_MIN) : cfg_fast_wait;
    end

    // Capture at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            rb_q   <= RB_W'(1);
            eb_q   <= '0;
            fast_q <= FAST_W'(FAST_MIN);
        end else if (accept) begin
            word_q <= word_addr;
            rb_q   <= rb_clamp;
            eb_q   <= cfg_ext_bits;
            fast_q <= fast_clamp;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)               state_d = ST_ROW;
            ST_ROW:  if (tmr_last)             state_d = ST_COL;
            ST_COL:  if (tmr_last && ext_last) state_d = ST_DONE;
            ST_DONE:                           state_d = ST_IDLE;
            default:                           state_d = ST_IDLE;
        endcase
    end

    // Timer and counter control
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(fast_q);
        ext_step = 1'b0;
        if (accept) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(slow_clamp);
        end else if (state_q == ST_ROW && tmr_last) begin
            tmr_load = 1'b1;
        end else if (state_q == ST_COL && tmr_last && !ext_last) begin
            tmr_load = 1'b1;
            ext_step = 1'b1;
        end
    end

    // Outputs decoded from state
    always_comb begin
        ready = 1'b0;
        ras   = 1'b0;
        cas   = 1'b0;
        done  = 1'b0;
        unique case (state_q)
            ST_IDLE: ready = 1'b1;
            ST_ROW:  ras   = 1'b1;
            ST_COL:  begin
                ras = 1'b1;
                cas = 1'b1;
            end
            ST_DONE: done  = 1'b1;
            default: ready = 1'b0;
        endcase
    end

    dram_wait_timer #(
        .CNT_W(TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    dram_ext_counter #(
        .EXT_W(EXT_W),
        .CNT_W(CNT_W)
    ) u_ext (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .step     (ext_step),
        .ext_bits (eb_q),
        .count    (ext_cnt),
        .at_last  (ext_last)
    );

    dram_addr_former #(
        .ADDR_W (ADDR_W),
        .RB_W   (RB_W),
        .EXT_W  (EXT_W),
        .CNT_W  (CNT_W),
        .MA_W   (MA_W)
    ) u_addr (
        .word     (word_q),
        .row_bits (rb_q),
        .ext_bits (eb_q),
        .ext_cnt  (ext_cnt),
        .sel_row  (state_q == ST_ROW),
        .sel_col  (state_q == ST_COL),
        .ma       (mem_addr)
    );

endmodule

// File: rtl/dram_rc_seq_chk.sv
module dram_rc_seq_chk #(
    parameter int MA_W = 18
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req,
    input logic [3:0]      mode,
    input logic            ready,
    input logic [MA_W-1:0] mem_addr,
    input logic            ras,
    input logic            cas,
    input logic            done
);

    assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req && mode[3:2] != 2'b01) |=> ready);

    assert_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req && mode[3:2] == 2'b01) |=> (ras && !cas && !ready));

    assert_cas_needs_ras_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cas |-> ras);

    assert_done_strobes_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ras && !cas && !ready && mem_addr == '0));

    assert_done_then_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (ready && !done));

    assert_cas_ends_in_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas) |-> done);

    assert_busy_ignores_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ras && !done) |=> !ready);

    assert_idle_bus_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (mem_addr == '0 && !ras && !cas && !done));

endmodule

bind dram_rc_seq dram_rc_seq_chk #(
    .MA_W(MA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .mode     (mode),
    .ready    (ready),
    .mem_addr (mem_addr),
    .ras      (ras),
    .cas      (cas),
    .done     (done)
);

// File: tb/tb_dram_rc_seq.sv
module tb_dram_rc_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [3:0]  mode = 4'b0;
    logic [15:0] word_addr = 16'h0;
    logic [4:0]  cfg_row_bits = 5'd8;
    logic [1:0]  cfg_ext_bits = 2'd0;
    logic [3:0]  cfg_slow_wait = 4'd2;
    logic [2:0]  cfg_fast_wait = 3'd1;
    logic        ready;
    logic [17:0] mem_addr;
    logic        ras;
    logic        cas;
    logic        done;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic        ras;
        logic        cas;
        logic        done;
        logic        rdy;
        logic [17:0] ma;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #5 clk = ~clk;

    dram_rc_seq dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req           (req),
        .mode          (mode),
        .word_addr     (word_addr),
        .cfg_row_bits  (cfg_row_bits),
        .cfg_ext_bits  (cfg_ext_bits),
        .cfg_slow_wait (cfg_slow_wait),
        .cfg_fast_wait (cfg_fast_wait),
        .ready         (ready),
        .mem_addr      (mem_addr),
        .ras           (ras),
        .cas           (cas),
        .done          (done)
    );

    task automatic push(input logic r, input logic c, input logic d, input logic y,
                        input logic [17:0] a, input string t);
        exp_t e;
        e.ras = r; e.cas = c; e.done = d; e.rdy = y; e.ma = a; e.tag = t;
        exp_q.push_back(e);
    endtask

    // Monitor: one expected item per cycle, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n && exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            total++;
            if (ras !== e.ras || cas !== e.cas || done !== e.done ||
                ready !== e.rdy || mem_addr !== e.ma) begin
                bad++;
                $display("FAIL %s: got ras=%b cas=%b done=%b ready=%b ma=%h, expected ras=%b cas=%b done=%b ready=%b ma=%h",
                         e.tag, ras, cas, done, ready, mem_addr,
                         e.ras, e.cas, e.done, e.rdy, e.ma);
            end
        end
    end

    task automatic wait_drain();
        while (exp_q.size() != 0) @(posedge clk);
        #2;
    endtask

    // Driver: issues one access and queues the full expected trace
    task automatic run_seq(input logic [15:0] a, input logic [4:0] rb, input logic [1:0] eb,
                           input logic [3:0] sw, input logic [2:0] fw, input logic [3:0] md,
                           input bit disturb, input string tag_row);
        int rbc, swc, fwc, colw;
        logic [17:0] rowv, colv;
        wait_drain();
        word_addr = a; cfg_row_bits = rb; cfg_ext_bits = eb;
        cfg_slow_wait = sw; cfg_fast_wait = fw; mode = md; req = 1'b1;
        @(posedge clk);
        #1;
        req = 1'b0;
        // R11 clamping
        rbc = (rb == 0) ? 1 : ((rb > 15) ? 15 : int'(rb));
        swc = (sw < 2) ? 2 : int'(sw);
        fwc = (fw == 0) ? 1 : int'(fw);
        colw = 16 - rbc;
        rowv = 18'(a >> colw);
        for (int i = 0; i < swc; i++) push(1, 0, 0, 0, rowv, tag_row);             // R3
        for (int k = 0; k < (1 << eb); k++) begin                                  // R5
            colv = (18'(a & 16'((32'd1 << colw) - 1)) << eb) | 18'(k);             // R4
            for (int j = 0; j < fwc; j++) push(1, 1, 0, 0, colv, "R4/R5/R6");
        end
        push(0, 0, 1, 0, 18'h0, "R7 done");
        push(0, 0, 0, 1, 18'h0, "R7 ready");
        if (disturb) begin
            // R8, R9: new request and new inputs while busy
            word_addr = ~a; cfg_row_bits = 5'd3; cfg_ext_bits = ~eb;
            cfg_slow_wait = 4'd9; cfg_fast_wait = 3'd5; mode = 4'b0100; req = 1'b1;
            repeat (2) @(posedge clk);
            #1;
            req = 1'b0;
        end
    endtask

    // R2: requests with an inactive mode
    task automatic run_bad_mode(input logic [3:0] md);
        wait_drain();
        word_addr = 16'hFFFF; mode = md; cfg_ext_bits = 2'd3; req = 1'b1;
        @(posedge clk);
        #1;
        for (int i = 0; i < 3; i++) push(0, 0, 0, 1, 18'h0, "R2/R10 idle");
        @(posedge clk);
        #1;
        req = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        total++;
        if (ready !== 1'b1 || ras !== 1'b0 || cas !== 1'b0 || done !== 1'b0 || mem_addr !== 18'h0) begin
            bad++;
            $display("FAIL R1: got ready=%b ras=%b cas=%b done=%b ma=%h, expected 1 0 0 0 0",
                     ready, ras, cas, done, mem_addr);
        end
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        run_seq(16'hA5C3, 5'd8, 2'd2, 4'd3, 3'd2, 4'b0100, 1'b0, "R3 row");
        run_seq(16'h1234, 5'd9, 2'd0, 4'd2, 3'd1, 4'b0101, 1'b0, "R3 row");
        run_bad_mode(4'b1000);
        run_bad_mode(4'b0011);
        run_seq(16'hBEEF, 5'd6, 2'd3, 4'd4, 3'd1, 4'b0110, 1'b1, "R3/R8/R9 row");
        run_seq(16'h8001, 5'd0, 2'd1, 4'd0, 3'd0, 4'b0111, 1'b0, "R11 row");
        run_seq(16'h7FFE, 5'd20, 2'd2, 4'd1, 3'd7, 4'b0100, 1'b0, "R11 row");
        run_seq(16'hC3A5, 5'd12, 2'd3, 4'd15, 3'd3, 4'b0100, 1'b1, "R3/R9 row");
        wait_drain();
        repeat (2) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got no end, expected finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule